// File: doc/BRIEF.md
# Quarter Change Selector

This block decides how a 25-cent quarter is paid back from two coin reservoirs, one of dimes and one of nickels. It reads a saturated count from each reservoir counter and chooses the combination that uses the most dimes the reservoirs can supply. If no 25-cent combination can be paid, it raises a no-change flag and reports zero coins of each kind.

The choice is made combinationally. It is captured into output registers when the request input is high. A valid pulse one cycle later marks the fresh result. Between requests the outputs hold their last value. The reservoir counters, the coin release hardware and quarter detection are all outside the block.

Top module: `coin_change_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `out_dimes`, `out_nickels`, `no_chg` and `valid` are all cleared to 0 on that edge.
- R2: `valid` is high for exactly the cycle after each edge where `req` was sampled high, and low after every edge where `req` was sampled low.
- R3: `dime_cnt` is an unsigned count that saturates, so 3 means three or more dimes. `nick_cnt` is an unsigned count that saturates, so 6 or 7 means six or more nickels.
- R4: On a request with `dime_cnt` >= 2 and `nick_cnt` >= 1, the result is 2 dimes and 1 nickel.
- R5: If R4 does not apply, a request with `dime_cnt` >= 1 and `nick_cnt` >= 3 gives 1 dime and 3 nickels.
- R6: If neither R4 nor R5 applies, a request with `nick_cnt` >= 5 gives 0 dimes and 5 nickels.
- R7: If no rule among R4 to R6 applies, the request sets `no_chg` to 1 and sets both counts to 0.
- R8: Whenever `no_chg` is 0 after a request, the coins reported are worth exactly 25 cents. No reported count exceeds the corresponding input count.
- R9: After an edge where `req` is low, `out_dimes`, `out_nickels` and `no_chg` keep their previous values, whatever the count inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Capture strobe for one change decision |
| dime_cnt | input | 2 | Saturated dime reservoir count |
| nick_cnt | input | 3 | Saturated nickel reservoir count |
| out_dimes | output | 2 | Dimes to dispense |
| out_nickels | output | 3 | Nickels to dispense |
| no_chg | output | 1 | No 25-cent combination can be paid |
| valid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The only state is one result register and one strobe flag, so any fault shows up at the ports on the edge right after the request. A wrong priority shows as a result that still adds up to 25 cents but has fewer dimes than the reservoir allowed. A wrong capture condition shows as outputs that change on a cycle without a request, or as a valid pulse that is missing or lasts too long. The bench covers every count pair. For each pair it checks the captured result first, and then checks one idle cycle with different inputs.

// File: rtl/coin_change_sel.sv
module coin_change_sel #(
  parameter int DW = 2,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [DW-1:0] dime_cnt,
  input  logic [NW-1:0] nick_cnt,
  output logic [DW-1:0] out_dimes,
  output logic [NW-1:0] out_nickels,
  output logic          no_chg,
  output logic          valid
);
  localparam logic [DW-1:0] D1 = DW'(1);
  localparam logic [DW-1:0] D2 = DW'(2);
  localparam logic [NW-1:0] N1 = NW'(1);
  localparam logic [NW-1:0] N3 = NW'(3);
  localparam logic [NW-1:0] N5 = NW'(5);

  logic opt_a, opt_b, opt_c;
  logic [DW-1:0] sel_d;
  logic [NW-1:0] sel_n;

  assign opt_a = (dime_cnt >= D2) && (nick_cnt >= N1);
  assign opt_b = (dime_cnt >= D1) && (nick_cnt >= N3);
  assign opt_c = (nick_cnt >= N5);

  assign sel_d = opt_a ? D2 : (opt_b ? D1 : '0);
  assign sel_n = opt_a ? N1 : (opt_b ? N3 : (opt_c ? N5 : '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dimes   <= '0;
      out_nickels <= '0;
      no_chg      <= 1'b0;
      valid       <= 1'b0;
    end else begin
      valid <= req;
      if (req) begin
        out_dimes   <= sel_d;
        out_nickels <= sel_n;
        no_chg      <= !(opt_a || opt_b || opt_c);
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !valid);
  // R7
  nochg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    no_chg |-> (out_dimes == '0 && out_nickels == '0));
  // R8
  value_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !no_chg) |-> (int'(out_dimes) * 10 + int'(out_nickels) * 5 == 25));
  // R8
  supply_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> (out_dimes <= $past(dime_cnt) && out_nickels <= $past(nick_cnt)));
  // R4
  dime_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req && dime_cnt >= D2 && nick_cnt >= N1) |=> (out_dimes == D2));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(out_dimes) && $stable(out_nickels) && $stable(no_chg)));
endmodule

// File: tb/coin_change_sel_test.sv
module coin_change_sel_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] dime_cnt = '0;
  logic [2:0] nick_cnt = '0;
  logic [1:0] out_dimes;
  logic [2:0] out_nickels;
  logic no_chg, valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coin_change_sel uut (
    .clk(clk), .rst(rst), .req(req), .dime_cnt(dime_cnt), .nick_cnt(nick_cnt),
    .out_dimes(out_dimes), .out_nickels(out_nickels), .no_chg(no_chg), .valid(valid)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_change(int d, int n, output int ed, output int en, output int ez);
    ed = 0; en = 0; ez = 1;
    for (int k = 2; k >= 0; k--) begin
      int need = (25 - 10 * k) / 5;
      if (ez == 1 && k <= d && need <= n) begin
        ed = k; en = need; ez = 0;
      end
    end
  endtask

  initial begin
    int ed, en, ez;
    repeat (3) @(negedge clk);
    check("R1 dimes", out_dimes, 0);
    check("R1 nickels", out_nickels, 0);
    check("R1 nochg", no_chg, 0);
    check("R1 valid", valid, 0);
    rst = 1'b0;
    for (int d = 0; d < 4; d++) begin
      for (int n = 0; n < 8; n++) begin
        expect_change(d, n, ed, en, ez);
        @(negedge clk);
        dime_cnt = 2'(d); nick_cnt = 3'(n); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (ed == 2) begin
          check("R4 dimes", out_dimes, ed);
        end else if (ed == 1) begin
          check("R5 dimes", out_dimes, ed);
        end else if (ez == 0) begin
          check("R6 dimes", out_dimes, ed);
        end else begin
          check("R7 dimes", out_dimes, ed);
        end
        check("R3 nickels", out_nickels, en);
        check("R7 nochg", no_chg, ez);
        check("R2 valid high", valid, 1);
        if (ez == 0) check("R8 value", out_dimes * 10 + out_nickels * 5, 25);
        dime_cnt = 2'(3 - d); nick_cnt = 3'(7 - n);
        @(negedge clk);
        check("R9 dimes", out_dimes, ed);
        check("R9 nickels", out_nickels, en);
        check("R9 nochg", no_chg, ez);
        check("R2 valid low", valid, 0);
      end
    end
    @(negedge clk);
    dime_cnt = 2'd0; nick_cnt = 3'd0; req = 1'b1;
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid nochg", no_chg, 0);
    check("R1 mid valid", valid, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule